// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a free-running supervision counter for a small controller. It advances once for every machine-cycle enable it receives and, if software fails to service it before the count reaches its all-ones limit, raises a reset request for the rest of the chip. Nothing software can write turns the counter off. The reset request stays inside the chip, goes to the core reset sequencer and is never driven out on the board reset pin.

Servicing works through a write-only register that takes an ordered two-byte key. A write of 1Eh arms the sequence. The very next write to the register must then be E1h, and it returns the count to zero. Any other second write breaks the sequence, and software has to begin again with 1Eh. The counter keeps running while the processor idles. It freezes and holds its value while the chip is powered down. The present count is brought out for debug visibility only.

When the limit is reached, the reset request stays asserted for a fixed number of machine cycles. The counter then drops back to zero, and supervision begins again from the start.

Top module: `keyed_watchdog`

## Requirements
- R1: While the asynchronous reset is active, and on the first cycle after it is released, the count is 0 and the reset request is low.
- R2: Each clock edge with the machine-cycle enable high advances the count by exactly one, unless a rule below takes precedence. A clock edge with the enable low leaves the count unchanged.
- R3: The idle flag has no effect on counting.
- R4: While the power-down flag is high, the count holds its value whatever the machine-cycle enable does.
- R5: A service write of 1Eh followed by a service write of E1h sets the count to 0 on the clock edge of the E1h write. Any number of cycles without a write may fall between the two writes.
- R6: The sequence is broken when the write that follows an armed 1Eh carries any value other than E1h, including a second 1Eh. The E1h that comes after such a broken write does not clear the count. An E1h that is not preceded by an armed 1Eh does not clear it either, and neither does a write of any other value.
- R7: When the enable is high on the same edge as the completing E1h write, the service clear wins and the count becomes 0.
- R8: While the count is 3FFFh and no reset request is in progress, the next clock edge raises the reset request. The request stays high for RST_LEN edges that carry the machine-cycle enable. The count holds 3FFFh throughout, and it becomes 0 on the edge where the request falls.
- R9: A completing E1h write on an edge where the count is already 3FFFh does not prevent the reset request. Writes made while the request is high do not clear the count, and they leave the key sequence disarmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous reset, active low |
| mc_tick | input | 1 | Machine-cycle enable, one clock wide per machine cycle |
| svc_wr | input | 1 | Write strobe for the service register |
| svc_data | input | 8 | Byte written to the service register |
| idle_mode | input | 1 | Processor idle status |
| pdown_mode | input | 1 | Power-down status |
| wdt_rst_req | output | 1 | Internal reset request to the core reset sequencer |
| wdt_count | output | 14 | Present count, for debug visibility |

## Verification
Two pairs of events can land on the same edge. A completing E1h write can meet a machine-cycle tick, and a completing E1h write can meet the edge that detects the 3FFFh limit. The bench provokes the first case by driving the tick together with the second key byte, and it expects the count to read 0 rather than the old count plus one. It provokes the second case by arming the key a few counts before the limit and sending E1h on the cycle the limit is seen. There it expects the reset request to rise with the count still at 3FFFh. Random traffic then mixes keys, stray bytes, power-down and tick gaps against a cycle-by-cycle reference model.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic {
    KEY_WAIT_FIRST  = 1'b0,
    KEY_WAIT_SECOND = 1'b1
  } key_state_e;

  // Next key state after a register write event; any write while armed disarms.
  function automatic key_state_e key_advance(
    input key_state_e cur,
    input logic       wr,
    input logic       is_first_key
  );
    key_state_e nxt;
    nxt = cur;
    if (wr) begin
      if (cur == KEY_WAIT_SECOND) nxt = KEY_WAIT_FIRST;
      else if (is_first_key)      nxt = KEY_WAIT_SECOND;
      else                        nxt = KEY_WAIT_FIRST;
    end
    return nxt;
  endfunction

  // Bit count needed to hold the value n.
  function automatic int unsigned bits_for(input int unsigned n);
    int unsigned b;
    b = 1;
    while ((n >> b) != 0) b++;
    return b;
  endfunction

endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
#(
  parameter int unsigned           DATA_W     = 8,
  parameter logic [DATA_W-1:0]     KEY_FIRST  = 8'h1E,
  parameter logic [DATA_W-1:0]     KEY_SECOND = 8'hE1
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              flush,
  input  logic              wr,
  input  logic [DATA_W-1:0] data,
  output logic              unlock
);

  key_state_e state_q;
  key_state_e state_d;
  logic       first_hit;
  logic       second_hit;

  assign first_hit  = (data == KEY_FIRST);
  assign second_hit = (data == KEY_SECOND);

  always_comb begin
    if (flush) state_d = KEY_WAIT_FIRST;
    else       state_d = key_advance(state_q, wr, first_hit);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) state_q <= KEY_WAIT_FIRST;
    else         state_q <= state_d;
  end

  assign unlock = wr && !flush && (state_q == KEY_WAIT_SECOND) && second_hit;

  // R6: whatever the second write carries, the sequence is spent afterwards
  a_r6_write_disarms: assert property (@(posedge clk) disable iff (!arst_n)
    (wr && state_q == KEY_WAIT_SECOND) |=> (state_q == KEY_WAIT_FIRST));

  // R9: while a reset request is pending the key stays disarmed
  a_r9_flush_disarms: assert property (@(posedge clk) disable iff (!arst_n)
    flush |=> (state_q == KEY_WAIT_FIRST));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W        = 14,
  parameter bit          HOLD_IN_IDLE = 1'b0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             tick,
  input  logic             idle,
  input  logic             pdown,
  input  logic             hold,
  input  logic             wrap_clr,
  input  logic             svc_clr,
  output logic [CNT_W-1:0] count,
  output logic             at_limit
);

  localparam logic [CNT_W-1:0] LIMIT = {CNT_W{1'b1}};

  logic             run;
  logic [CNT_W-1:0] count_d;

  assign run = tick && !pdown && !(HOLD_IN_IDLE && idle);

  always_comb begin
    count_d = count;
    if (wrap_clr)     count_d = '0;
    else if (hold)    count_d = count;
    else if (svc_clr) count_d = '0;
    else if (run)     count_d = count + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) count <= '0;
    else         count <= count_d;
  end

  assign at_limit = (count == LIMIT);

  // R2: a plain tick moves the count forward by one
  a_r2_single_step: assert property (@(posedge clk) disable iff (!arst_n)
    (run && !hold && !wrap_clr && !svc_clr) |=> (count == $past(count) + 1'b1));

  // R4: power-down freezes the count
  a_r4_pdown_freeze: assert property (@(posedge clk) disable iff (!arst_n)
    (pdown && !wrap_clr && !svc_clr) |=> $stable(count));

  // R7: service clear beats a coincident tick
  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!arst_n)
    (svc_clr && tick && !hold && !wrap_clr) |=> (count == '0));

endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse
  import wdt_pkg::*;
#(
  parameter int unsigned RST_LEN = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick,
  input  logic fire,
  output logic active,
  output logic done_now
);

  localparam int unsigned PW = bits_for(RST_LEN);
  localparam logic [PW-1:0] LEN = PW'(RST_LEN);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)              left_q <= '0;
    else if (fire)            left_q <= LEN;
    else if (active && tick)  left_q <= left_q - 1'b1;
  end

  assign active   = (left_q != '0);
  assign done_now = active && tick && (left_q == PW'(1));

  // R8: detection of the limit starts the request on the next edge
  a_r8_fire_starts: assert property (@(posedge clk) disable iff (!arst_n)
    fire |=> active);

  // R8: the request length is counted in machine cycles only
  a_r8_no_tick_holds: assert property (@(posedge clk) disable iff (!arst_n)
    (active && !tick) |=> active);

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int unsigned         CNT_W        = 14,
  parameter int unsigned         DATA_W       = 8,
  parameter logic [DATA_W-1:0]   KEY_FIRST    = 8'h1E,
  parameter logic [DATA_W-1:0]   KEY_SECOND   = 8'hE1,
  parameter int unsigned         RST_LEN      = 4,
  parameter bit                  HOLD_IN_IDLE = 1'b0
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              mc_tick,
  input  logic              svc_wr,
  input  logic [DATA_W-1:0] svc_data,
  input  logic              idle_mode,
  input  logic              pdown_mode,
  output logic              wdt_rst_req,
  output logic [CNT_W-1:0]  wdt_count
);

  localparam logic [CNT_W-1:0] LIMIT = {CNT_W{1'b1}};

  logic pulse_active;
  logic pulse_done;
  logic at_limit;
  logic expire;
  logic svc_unlock;
  logic freeze;

  assign expire = at_limit && !pulse_active;
  assign freeze = pulse_active || expire;

  wdt_key_seq #(
    .DATA_W     (DATA_W),
    .KEY_FIRST  (KEY_FIRST),
    .KEY_SECOND (KEY_SECOND)
  ) u_key (
    .clk    (clk),
    .arst_n (arst_n),
    .flush  (freeze),
    .wr     (svc_wr),
    .data   (svc_data),
    .unlock (svc_unlock)
  );

  wdt_counter #(
    .CNT_W        (CNT_W),
    .HOLD_IN_IDLE (HOLD_IN_IDLE)
  ) u_cnt (
    .clk      (clk),
    .arst_n   (arst_n),
    .tick     (mc_tick),
    .idle     (idle_mode),
    .pdown    (pdown_mode),
    .hold     (freeze),
    .wrap_clr (pulse_done),
    .svc_clr  (svc_unlock),
    .count    (wdt_count),
    .at_limit (at_limit)
  );

  wdt_rst_pulse #(
    .RST_LEN (RST_LEN)
  ) u_pulse (
    .clk      (clk),
    .arst_n   (arst_n),
    .tick     (mc_tick),
    .fire     (expire),
    .active   (pulse_active),
    .done_now (pulse_done)
  );

  assign wdt_rst_req = pulse_active;

  // R8: the count sits at its limit for the whole request
  a_r8_hold_limit: assert property (@(posedge clk) disable iff (!arst_n)
    wdt_rst_req |-> (wdt_count == LIMIT));

  // R8: the count restarts from zero as the request ends
  a_r8_clear_on_end: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(wdt_rst_req) |-> (wdt_count == '0));

  // R9: a key completing on the limit edge does not stop the request
  a_r9_expiry_wins: assert property (@(posedge clk) disable iff (!arst_n)
    (at_limit && !wdt_rst_req) |=> wdt_rst_req);

endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;

  localparam int CW   = 14;
  localparam int LEN  = 4;
  localparam int MAXV = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          arst_n = 1'b0;
  logic          mc_tick = 1'b0;
  logic          svc_wr = 1'b0;
  logic [7:0]    svc_data = 8'h00;
  logic          idle_mode = 1'b0;
  logic          pdown_mode = 1'b0;
  logic          wdt_rst_req;
  logic [CW-1:0] wdt_count;

  int checks = 0;
  int errors = 0;

  int m_cnt = 0;
  bit m_armed = 0;
  int m_left = 0;

  always #4 clk = ~clk;

  keyed_watchdog u_dut (
    .clk(clk), .arst_n(arst_n), .mc_tick(mc_tick), .svc_wr(svc_wr),
    .svc_data(svc_data), .idle_mode(idle_mode), .pdown_mode(pdown_mode),
    .wdt_rst_req(wdt_rst_req), .wdt_count(wdt_count)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference behaviour for one clock edge, written from the requirements.
  task automatic model_edge();
    bit completes;
    if (m_left > 0) begin
      m_armed = 0;
      if (mc_tick) begin
        m_left = m_left - 1;
        if (m_left == 0) m_cnt = 0;
      end
    end else if (m_cnt == MAXV) begin
      m_left  = LEN;
      m_armed = 0;
    end else begin
      completes = svc_wr && m_armed && (svc_data == 8'hE1);
      if (svc_wr) m_armed = !m_armed && (svc_data == 8'h1E);
      if (completes)                   m_cnt = 0;
      else if (mc_tick && !pdown_mode) m_cnt = m_cnt + 1;
    end
  endtask

  task automatic cyc(input bit t, input bit w, input logic [7:0] d,
                     input bit id, input bit pd);
    mc_tick = t; svc_wr = w; svc_data = d; idle_mode = id; pdown_mode = pd;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(int'(wdt_count) == m_cnt, "R2", "model count", int'(wdt_count), m_cnt);
    chk(wdt_rst_req == (m_left > 0), "R8", "model request",
        int'(wdt_rst_req), int'(m_left > 0));
    svc_wr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(wdt_count == 0, "R1", "count in reset", int'(wdt_count), 0);
    chk(wdt_rst_req == 0, "R1", "request in reset", int'(wdt_rst_req), 0);
    arst_n = 1'b1;
    cyc(0, 0, 8'h00, 0, 0);
    chk(wdt_count == 0, "R1", "count after release", int'(wdt_count), 0);

    for (int i = 0; i < 10; i++) cyc(1, 0, 8'h00, 0, 0);
    chk(wdt_count == 10, "R2", "ten ticks", int'(wdt_count), 10);
    for (int i = 0; i < 3; i++) cyc(0, 0, 8'h00, 0, 0);
    chk(wdt_count == 10, "R2", "no tick hold", int'(wdt_count), 10);
    for (int i = 0; i < 5; i++) cyc(1, 0, 8'h00, 1, 0);
    chk(wdt_count == 15, "R3", "idle counts", int'(wdt_count), 15);
    for (int i = 0; i < 5; i++) cyc(1, 0, 8'h00, 0, 1);
    chk(wdt_count == 15, "R4", "power-down hold", int'(wdt_count), 15);

    cyc(1, 1, 8'h1E, 0, 0);
    cyc(1, 0, 8'h00, 0, 0);
    cyc(0, 0, 8'h00, 0, 0);
    cyc(0, 1, 8'hE1, 0, 0);
    chk(wdt_count == 0, "R5", "key clears", int'(wdt_count), 0);

    for (int i = 0; i < 4; i++) cyc(1, 0, 8'h00, 0, 0);
    cyc(1, 1, 8'h1E, 0, 0);
    cyc(1, 1, 8'h1E, 0, 0);
    cyc(1, 1, 8'hE1, 0, 0);
    chk(wdt_count == 7, "R6", "doubled first key", int'(wdt_count), 7);
    cyc(1, 1, 8'hE1, 0, 0);
    chk(wdt_count == 8, "R6", "lone second key", int'(wdt_count), 8);
    cyc(1, 1, 8'h5A, 0, 0);
    cyc(1, 1, 8'hE1, 0, 0);
    chk(wdt_count == 10, "R6", "stray byte then key", int'(wdt_count), 10);

    cyc(1, 1, 8'h1E, 0, 0);
    chk(wdt_count == 11, "R7", "armed tick", int'(wdt_count), 11);
    cyc(1, 1, 8'hE1, 0, 0);
    chk(wdt_count == 0, "R7", "clear beats tick", int'(wdt_count), 0);

    while (int'(wdt_count) < MAXV - 3) cyc(1, 0, 8'h00, 0, 0);
    cyc(1, 1, 8'h1E, 0, 0);
    cyc(1, 0, 8'h00, 0, 0);
    cyc(1, 0, 8'h00, 0, 0);
    chk(wdt_count == CW'(MAXV), "R8", "at limit", int'(wdt_count), MAXV);
    chk(wdt_rst_req == 0, "R8", "not yet requested", int'(wdt_rst_req), 0);
    cyc(1, 1, 8'hE1, 0, 0);
    chk(wdt_rst_req == 1, "R9", "expiry beats key", int'(wdt_rst_req), 1);
    chk(wdt_count == CW'(MAXV), "R9", "limit kept", int'(wdt_count), MAXV);
    cyc(0, 1, 8'h1E, 0, 0);
    chk(wdt_rst_req == 1, "R8", "held without tick", int'(wdt_rst_req), 1);
    for (int i = 0; i < LEN - 1; i++) begin
      cyc(1, 1, (i % 2 == 0) ? 8'hE1 : 8'h1E, 0, 0);
      chk(wdt_rst_req == 1, "R8", "request held", int'(wdt_rst_req), 1);
      chk(wdt_count == CW'(MAXV), "R9", "writes ignored", int'(wdt_count), MAXV);
    end
    cyc(1, 0, 8'h00, 0, 0);
    chk(wdt_rst_req == 0, "R8", "request ends", int'(wdt_rst_req), 0);
    chk(wdt_count == 0, "R8", "wrap to zero", int'(wdt_count), 0);
    cyc(1, 0, 8'h00, 0, 0);
    cyc(1, 1, 8'hE1, 0, 0);
    chk(wdt_count == 2, "R9", "disarmed after request", int'(wdt_count), 2);

    for (int i = 0; i < 20000; i++) begin
      int sel;
      logic [7:0] d;
      sel = int'($urandom % 4);
      d = (sel == 0) ? 8'h1E : (sel == 1) ? 8'hE1 : 8'($urandom);
      cyc(($urandom % 4) != 0, ($urandom % 6) == 0, d,
          ($urandom % 3) == 0, ($urandom % 16) == 0);
    end

    base = int'(wdt_count);
    for (int i = 0; i < 6; i++) cyc(1, 0, 8'h00, 0, 0);
    chk(wdt_rst_req == 1 || wdt_count != 0, "R2", "still supervising",
        int'(wdt_count), base);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule